// File: doc/BRIEF.md
# Single-Frame Receive Buffer

This block sits between the receive half of an Ethernet MAC and a DMA engine and stores exactly one frame. The MAC side presents payload bytes one per cycle with start and end markers. When the end marker is accepted the frame becomes visible to the DMA side, which pulls it as a byte stream with a valid/ready handshake in bursts of whatever length it likes. Four extra bytes, standing in for the checksum that software expects after the payload, follow the payload and are included in the reported length.

While a frame is held, the block refuses new ones. A frame whose start arrives while the store is occupied is thrown away whole and counted. A frame longer than the store is also thrown away. Two sticky flags record both kinds of drop and are cleared by write-one-to-clear pulses.

Top module: `rxbuf_one_frame`

## Requirements
- R1: `rx_ready` is 1 exactly when the remaining length `rem_len` is 0. After reset the store is empty, `rx_ready` is 1, `dma_valid` is 0, both flags are 0 and `lost_count` is 0.
- R2: A start marker that arrives while `rem_len` is nonzero discards that whole frame, sets `overrun_flag`, and increments `lost_count`, which saturates at its maximum value. The held frame, its length and its read position are unchanged.
- R3: A frame with more than DEPTH payload bytes is discarded and sets `oversize_flag`. The store stays empty (`rem_len` 0, `dma_valid` 0). A frame of exactly DEPTH bytes is accepted.
- R4: In the cycle after the end byte of an accepted frame, `frame_len` and `rem_len` both equal the payload length plus 4.
- R5: `dma_valid` is 1 whenever `rem_len` is nonzero. Each cycle with `dma_valid` and `dma_ready` both 1 delivers one byte and lowers `rem_len` by one. While `dma_ready` is 0, `dma_data` and `rem_len` hold.
- R6: Every new frame is delivered from position zero. The payload bytes come in arrival order, followed by 4 bytes of value 0x00.
- R7: `dma_last` is 1 exactly on the final byte of the frame, which is when `rem_len` is 1.
- R8: The flags are sticky. `flag_clr` bit 0 clears `overrun_flag` and bit 1 clears `oversize_flag`. A drop in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Store empty, next frame will be taken |
| dma_valid | output | 1 | Byte available to the DMA side |
| dma_ready | input | 1 | DMA side takes the byte |
| dma_data | output | 8 | Byte at the read position |
| dma_last | output | 1 | Byte is the final one of the frame |
| frame_len | output | $clog2(DEPTH+5) | Length of the held frame including the 4 trailing bytes |
| rem_len | output | $clog2(DEPTH+5) | Bytes still to be pulled |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 oversize |
| overrun_flag | output | 1 | A frame was lost because the store was busy |
| oversize_flag | output | 1 | A frame was lost because it was too long |
| lost_count | output | LOSTW | Saturating count of busy-store drops |

## Verification
The bench builds the block with DEPTH of 8 and LOSTW of 2. With these values it can send every payload length from 1 through 10, which covers each accepted length up to the full store and two oversize lengths. It drains each frame with an irregular ready pattern. A four-value loss counter lets a short run of rejected frames reach saturation. It also covers a partial pull followed by a resumed drain, and a clear that coincides with a new drop.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    // Trailing bytes appended to every frame length (checksum pass-through)
    localparam int TRAIL_BYTES = 4;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_DROP = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic busy_drop;
        logic long_drop;
    } drop_flags_t;

    function automatic logic [15:0] sat_inc16(input logic [15:0] v, input logic [15:0] maxv);
        return (v >= maxv) ? maxv : v + 16'd1;
    endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DEPTH = 1536,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = (32'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;

endmodule

// File: rtl/rxbuf_fill.sv
module rxbuf_fill
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 1536,
    parameter int LOSTW = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             store_empty,
    input  logic [1:0]       flag_clr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data,
    output logic             commit,
    output logic [PW-1:0]    commit_len,
    output drop_flags_t      flags,
    output logic [LOSTW-1:0] lost_count
);
    fill_state_e   state;
    logic [PW-1:0] wcnt;

    logic start, take_start, refuse_start, body_byte, too_long;

    always_comb begin
        start        = rx_valid && rx_sof;
        take_start   = start && store_empty;
        refuse_start = start && !store_empty;
        body_byte    = rx_valid && !rx_sof && (state == FS_FILL);
        too_long     = body_byte && (wcnt == PW'(DEPTH));
        wr_en        = take_start || (body_byte && !too_long);
        wr_addr      = take_start ? '0 : AW'(wcnt);
        wr_data      = rx_data;
        commit       = wr_en && rx_eof;
        commit_len   = take_start ? PW'(1) : wcnt + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            wcnt  <= '0;
        end else if (take_start) begin
            state <= rx_eof ? FS_IDLE : FS_FILL;
            wcnt  <= PW'(1);
        end else if (refuse_start) begin
            state <= rx_eof ? FS_IDLE : FS_DROP;
        end else if (body_byte) begin
            if (too_long) begin
                state <= rx_eof ? FS_IDLE : FS_DROP;
            end else begin
                wcnt <= wcnt + PW'(1);
                if (rx_eof) state <= FS_IDLE;
            end
        end else if (rx_valid && rx_eof && state == FS_DROP) begin
            state <= FS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            lost_count <= '0;
        end else begin
            flags.busy_drop <= (flags.busy_drop && !flag_clr[0]) || refuse_start;
            flags.long_drop <= (flags.long_drop && !flag_clr[1]) || too_long;
            if (refuse_start)
                lost_count <= LOSTW'(sat_inc16(16'(lost_count), 16'((1 << LOSTW) - 1)));
        end
    end

    AST_FILL_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        commit |-> store_empty); // R2
    AST_BUSY_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.busy_drop && !flag_clr[0]) |=> flags.busy_drop); // R8
    AST_LONG_FLAG_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        too_long |=> flags.long_drop); // R3
    AST_LOST_NEVER_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (lost_count != 0) |=> (lost_count != 0)); // R2

endmodule

// File: rtl/rxbuf_drain.sv
module rxbuf_drain
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 1536,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(DEPTH + TRAIL_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [PW-1:0] commit_len,
    input  logic          dma_ready,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          store_empty,
    output logic          dma_valid,
    output logic          dma_last,
    output logic [7:0]    dma_data,
    output logic [LW-1:0] frame_len,
    output logic [LW-1:0] rem_len
);
    logic [LW-1:0] rd_pos;
    logic [PW-1:0] pay_len;
    logic          pull;

    always_comb begin
        store_empty = (rem_len == '0);
        dma_valid   = !store_empty;
        dma_last    = (rem_len == LW'(1));
        pull        = dma_valid && dma_ready;
        rd_addr     = AW'(rd_pos);
        dma_data    = (rd_pos < LW'(pay_len)) ? rd_data : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pos    <= '0;
            rem_len   <= '0;
            pay_len   <= '0;
            frame_len <= '0;
        end else if (commit) begin
            rd_pos    <= '0;
            pay_len   <= commit_len;
            rem_len   <= LW'(commit_len) + LW'(TRAIL_BYTES);
            frame_len <= LW'(commit_len) + LW'(TRAIL_BYTES);
        end else if (pull) begin
            rd_pos  <= rd_pos + LW'(1);
            rem_len <= rem_len - LW'(1);
        end
    end

    AST_PULL_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        (pull && !commit) |=> (rem_len == $past(rem_len) - LW'(1))); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !dma_ready) |=> ($stable(rem_len) && $stable(dma_data))); // R5
    AST_POS_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        commit |=> (rd_pos == '0)); // R6
    AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        rem_len <= LW'(DEPTH + TRAIL_BYTES)); // R3

endmodule

// File: rtl/rxbuf_one_frame.sv
module rxbuf_one_frame
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 1536,
    parameter int LOSTW = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(DEPTH + TRAIL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             dma_valid,
    input  logic             dma_ready,
    output logic [7:0]       dma_data,
    output logic             dma_last,
    output logic [LW-1:0]    frame_len,
    output logic [LW-1:0]    rem_len,
    input  logic [1:0]       flag_clr,
    output logic             overrun_flag,
    output logic             oversize_flag,
    output logic [LOSTW-1:0] lost_count
);
    logic          wr_en, commit, store_empty;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;
    logic [PW-1:0] commit_len;
    drop_flags_t   flags;

    rxbuf_fill #(.DEPTH(DEPTH), .LOSTW(LOSTW)) u_fill (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .store_empty(store_empty), .flag_clr(flag_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .commit_len(commit_len),
        .flags(flags), .lost_count(lost_count)
    );

    rxbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rxbuf_drain #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst(rst),
        .commit(commit), .commit_len(commit_len),
        .dma_ready(dma_ready), .rd_data(rd_data), .rd_addr(rd_addr),
        .store_empty(store_empty), .dma_valid(dma_valid), .dma_last(dma_last),
        .dma_data(dma_data), .frame_len(frame_len), .rem_len(rem_len)
    );

    assign rx_ready      = store_empty;
    assign overrun_flag  = flags.busy_drop;
    assign oversize_flag = flags.long_drop;

    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        dma_last |-> dma_valid); // R7
    AST_LAST_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (dma_last && dma_ready) |=> rx_ready); // R1
    AST_BUSY_HOLDS_LEN: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && !dma_ready) |=> $stable(frame_len)); // R2

endmodule

// File: tb/rxbuf_one_frame_tb.sv
module rxbuf_one_frame_tb;
    localparam int DEPTH = 8;
    localparam int LOSTW = 2;
    localparam int LW = $clog2(DEPTH + 4 + 1);

    logic clk = 1'b0;
    logic rst;
    logic rx_valid, rx_sof, rx_eof;
    logic [7:0] rx_data;
    logic rx_ready, dma_valid, dma_ready, dma_last;
    logic [7:0] dma_data;
    logic [LW-1:0] frame_len, rem_len;
    logic [1:0] flag_clr;
    logic overrun_flag, oversize_flag;
    logic [LOSTW-1:0] lost_count;

    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rxbuf_one_frame #(.DEPTH(DEPTH), .LOSTW(LOSTW)) u_dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_ready(rx_ready), .dma_valid(dma_valid), .dma_ready(dma_ready),
        .dma_data(dma_data), .dma_last(dma_last),
        .frame_len(frame_len), .rem_len(rem_len), .flag_clr(flag_clr),
        .overrun_flag(overrun_flag), .oversize_flag(oversize_flag),
        .lost_count(lost_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 37) & 8'hFF);
    endfunction

    // Drives one frame of len bytes; returns at the negedge after the last byte.
    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_data  = pat(seed, i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    // Drains from byte index k0 with an irregular ready pattern; starts at a negedge.
    task automatic drain(input int plen, input int seed, input int k0);
        int total = plen + 4;
        int k = k0;
        int cyc = 0;
        logic r;
        while (k < total) begin
            chk("R5 valid", int'(dma_valid), 1);
            chk("R5 remaining", int'(rem_len), total - k);
            chk("R6 data", int'(dma_data), (k < plen) ? int'(pat(seed, k)) : 0);
            chk("R7 last", int'(dma_last), (k == total - 1) ? 1 : 0);
            r = ((cyc + plen) % 3) != 2;
            dma_ready = r;
            @(negedge clk);
            if (r) k++;
            cyc++;
        end
        dma_ready = 1'b0;
        chk("R1 empty after drain valid", int'(dma_valid), 0);
        chk("R1 ready after drain", int'(rx_ready), 1);
    endtask

    task automatic clear_flags(input logic [1:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
        dma_ready = 1'b0; flag_clr = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset rx_ready", int'(rx_ready), 1);
        chk("R1 reset dma_valid", int'(dma_valid), 0);
        chk("R1 reset overrun", int'(overrun_flag), 0);
        chk("R1 reset oversize", int'(oversize_flag), 0);
        chk("R1 reset lost", int'(lost_count), 0);

        // Sweep lengths: 1..DEPTH accepted (R4, R6), DEPTH+1, DEPTH+2 oversize (R3)
        for (int len = 1; len <= DEPTH + 2; len++) begin
            send_frame(len, len * 11);
            if (len <= DEPTH) begin
                chk("R4 frame_len", int'(frame_len), len + 4);
                chk("R4 rem_len", int'(rem_len), len + 4);
                chk("R1 busy rx_ready", int'(rx_ready), 0);
                drain(len, len * 11, 0);
            end else begin
                chk("R3 oversize flag", int'(oversize_flag), 1);
                chk("R3 store empty", int'(rem_len), 0);
                chk("R3 no dma_valid", int'(dma_valid), 0);
                chk("R3 ready kept", int'(rx_ready), 1);
                clear_flags(2'b10);
                chk("R8 oversize cleared", int'(oversize_flag), 0);
            end
        end

        // Partial pull then resume (R5, R6)
        send_frame(5, 200);
        dma_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        dma_ready = 1'b0;
        @(negedge clk);
        chk("R5 partial remaining", int'(rem_len), 7);
        chk("R5 partial data held", int'(dma_data), int'(pat(200, 2)));
        drain(5, 200, 2);

        // Overrun: frame held, four more frames arrive (R2)
        send_frame(3, 90);
        for (int j = 0; j < 4; j++) begin
            send_frame(j + 2, 150 + j);
            chk("R2 overrun flag", int'(overrun_flag), 1);
            chk("R2 lost count", int'(lost_count), (j + 1 > 3) ? 3 : j + 1);
            chk("R2 held length", int'(frame_len), 7);
            chk("R2 held remaining", int'(rem_len), 7);
        end
        // Clear coincident with a new drop: flag stays (R8)
        @(negedge clk);
        flag_clr = 2'b01;
        rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'h55;
        @(negedge clk);
        flag_clr = 2'b00; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        chk("R8 set wins over clear", int'(overrun_flag), 1);
        drain(3, 90, 0);
        clear_flags(2'b01);
        chk("R8 overrun cleared", int'(overrun_flag), 0);
        chk("R8 lost count kept", int'(lost_count), 3);

        // Next frame after drops starts clean (R6)
        send_frame(2, 7);
        drain(2, 7, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule